// File: doc/BRIEF.md
# Acknowledgement Start Timing Controller

This block sits beside a packet receiver and decides the moment at which an acknowledgement frame begins transmission after a frame that requested one. It tracks reception with a busy indication between the start-of-frame-delimiter pulse and the end-of-frame pulse. At the end of a frame it raises a one-cycle end-of-reception interrupt. When the finished frame asked for an acknowledgement, the block then times the acknowledgement start.

There are two timing modes, and both configuration bits are captured at the end-of-frame pulse. In unslotted mode the block counts symbol-period strobes and fires a start pulse itself. The count is 12 symbols (192 µs at 16 µs per symbol) by default, or 2 symbols when the short-turnaround bit is set. In slotted mode the block never fires on its own. After 6 symbols it reports a waiting-for-acknowledge status code, then hands the timing to an external trigger pin. A rising edge on that pin starts the acknowledgement after a fixed latency. The parameter defaults set that latency to 16 clock cycles, which is 16 µs with a 1 MHz clock. Any trigger edge outside the waiting window has no effect.

Top module: `ack_timing_ctrl`

## Requirements
- R1: After reset, busy_rx, rx_done_irq and ack_start are 0 and status is 2'b00 (idle).
- R2: A sfd_pulse in the idle state sets busy_rx in the next cycle, and busy_rx stays 1 until an end-of-frame pulse is accepted.
- R3: An eof_pulse while busy_rx is 1 gives a single-cycle rx_done_irq in the next cycle, with busy_rx 0 in that same cycle.
- R4: A frame that ends with eof_ack_req = 0 returns the block to idle. No ack_start follows, and status stays 2'b00.
- R5: In unslotted mode (cfg_slotted = 0 at end of frame) with cfg_short_turn = 0, ack_start is a one-cycle pulse in the cycle after the 12th sym_tick that follows the end of frame.
- R6: In unslotted mode with cfg_short_turn = 1, ack_start pulses in the cycle after the 2nd sym_tick that follows the end of frame.
- R7: In slotted mode, status becomes 2'b01 (waiting for acknowledge) in the cycle after the 6th sym_tick. It holds that value and issues no ack_start until a trigger edge arrives.
- R8: In the waiting state, a rising edge on trig_pin produces ack_start exactly TRIG_SYNC_STAGES + TRIG_LAT_CYC clock edges after the first edge that samples trig_pin high.
- R9: Rising edges on trig_pin before the 6-symbol ready point, or while no acknowledgement is pending, do not change ack_start or status.
- R10: In the cycle that ack_start is 1, status is 2'b00 and the block is idle. A following sfd_pulse is accepted again.
- R11: cfg_slotted and cfg_short_turn are sampled only at the accepted eof_pulse. Changes after that point do not alter the pending acknowledgement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfd_pulse | input | 1 | Start-of-frame delimiter detected, one cycle |
| eof_pulse | input | 1 | Last symbol of the frame received, one cycle |
| eof_ack_req | input | 1 | Frame requests an acknowledgement, valid with eof_pulse |
| sym_tick | input | 1 | One-cycle strobe per symbol period |
| cfg_slotted | input | 1 | 1 = acknowledgement start taken from the trigger pin |
| cfg_short_turn | input | 1 | 1 = 2-symbol turnaround in unslotted mode |
| trig_pin | input | 1 | External asynchronous acknowledgement trigger |
| busy_rx | output | 1 | Frame reception in progress |
| rx_done_irq | output | 1 | End-of-reception interrupt pulse |
| status | output | 2 | 2'b00 idle, 2'b01 waiting for acknowledge trigger |
| ack_start | output | 1 | Start acknowledgement transmission, one cycle |

## Verification
The assertions assume that sfd_pulse and eof_pulse are single-cycle strobes and that eof_ack_req is meaningful only alongside eof_pulse. They also assume that sym_tick never coincides with the end-of-frame pulse. The stimulus respects these assumptions: every strobe is driven for exactly one cycle, and symbol ticks are issued only after the end-of-frame cycle. Trigger pulses are held low for several cycles between uses, so each intended edge passes through the synchronizer as a distinct rising edge.

// File: rtl/ack_tim_pkg.sv
package ack_tim_pkg;

   typedef enum logic [2:0] {
      S_RX_ON   = 3'd0,
      S_BUSY    = 3'd1,
      S_COUNT   = 3'd2,
      S_WAIT    = 3'd3,
      S_TRIGDLY = 3'd4
   } ack_state_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_WAIT = 2'b01
   } ack_status_e;

   typedef enum logic [1:0] {
      M_LONG  = 2'd0,
      M_SHORT = 2'd1,
      M_SLOT  = 2'd2
   } ack_mode_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/ack_trig_sync.sv
module ack_trig_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise
);
   logic sync;
   logic prev_q;

   generate
      if (STAGES == 0) begin : g_direct
         assign sync = pin;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= STAGES'({sh_q, pin});
         end
         assign sync = sh_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync;
   end

   assign rise = sync & ~prev_q;
endmodule

// File: rtl/ack_sym_counter.sv
module ack_sym_counter #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         tick,
   input  logic [W-1:0] target,
   output logic         hit
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (!en)       cnt_q <= '0;
      else if (tick)      cnt_q <= cnt_q + 1'b1;
   end

   assign hit = en && tick && (cnt_q == target - 1'b1);
endmodule

// File: rtl/ack_lat_timer.sv
module ack_lat_timer #(
   parameter int LAT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic done
);
   localparam int LW = (LAT < 2) ? 1 : $clog2(LAT);
   localparam logic [LW-1:0] LAST = LW'(LAT - 1);

   logic [LW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (!en) cnt_q <= '0;
      else          cnt_q <= cnt_q + 1'b1;
   end

   assign done = en && (cnt_q == LAST);
endmodule

// File: rtl/ack_timing_ctrl.sv
module ack_timing_ctrl
   import ack_tim_pkg::*;
#(
   parameter int READY_SYM        = 6,
   parameter int SHORT_SYM        = 2,
   parameter int LONG_SYM         = 12,
   parameter int TRIG_LAT_CYC     = 16,
   parameter int TRIG_SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sfd_pulse,
   input  logic       eof_pulse,
   input  logic       eof_ack_req,
   input  logic       sym_tick,
   input  logic       cfg_slotted,
   input  logic       cfg_short_turn,
   input  logic       trig_pin,
   output logic       busy_rx,
   output logic       rx_done_irq,
   output logic [1:0] status,
   output logic       ack_start
);
   localparam int SYM_MAX = max3(READY_SYM, SHORT_SYM, LONG_SYM);
   localparam int SW      = $clog2(SYM_MAX + 1);

   generate
      if (READY_SYM < 1 || SHORT_SYM < 1 || LONG_SYM < 1) begin : g_bad_sym
         $error("symbol counts must be at least 1");
      end
      if (SHORT_SYM > LONG_SYM) begin : g_bad_order
         $error("short turnaround must not exceed long turnaround");
      end
      if (TRIG_LAT_CYC < 1) begin : g_bad_lat
         $error("trigger latency must be at least one cycle");
      end
      if (TRIG_SYNC_STAGES < 0 || TRIG_SYNC_STAGES > 3) begin : g_bad_sync
         $error("trigger synchronizer depth must be 0 to 3");
      end
   endgenerate

   ack_state_e  state_q;
   ack_mode_e   mode_q;
   ack_status_e status_q;
   logic        irq_q, ack_q;
   logic        trig_rise, sym_hit, lat_done;
   logic [SW-1:0] target;

   always_comb begin
      case (mode_q)
         M_SLOT:  target = SW'(READY_SYM);
         M_SHORT: target = SW'(SHORT_SYM);
         default: target = SW'(LONG_SYM);
      endcase
   end

   ack_trig_sync #(.STAGES(TRIG_SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .pin(trig_pin), .rise(trig_rise)
   );

   ack_sym_counter #(.W(SW)) i_symcnt (
      .clk(clk), .rst_n(rst_n), .en(state_q == S_COUNT),
      .tick(sym_tick), .target(target), .hit(sym_hit)
   );

   ack_lat_timer #(.LAT(TRIG_LAT_CYC)) i_lat (
      .clk(clk), .rst_n(rst_n), .en(state_q == S_TRIGDLY), .done(lat_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= S_RX_ON;
         mode_q   <= M_LONG;
         status_q <= ST_IDLE;
         irq_q    <= 1'b0;
         ack_q    <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         ack_q <= 1'b0;
         case (state_q)
            S_RX_ON: if (sfd_pulse) state_q <= S_BUSY;
            S_BUSY: if (eof_pulse) begin
               irq_q <= 1'b1;
               if (eof_ack_req) begin
                  mode_q  <= cfg_slotted ? M_SLOT : (cfg_short_turn ? M_SHORT : M_LONG);
                  state_q <= S_COUNT;
               end else begin
                  state_q <= S_RX_ON;
               end
            end
            S_COUNT: if (sym_hit) begin
               if (mode_q == M_SLOT) begin
                  status_q <= ST_WAIT;
                  state_q  <= S_WAIT;
               end else begin
                  ack_q   <= 1'b1;
                  state_q <= S_RX_ON;
               end
            end
            S_WAIT: if (trig_rise) state_q <= S_TRIGDLY;
            S_TRIGDLY: if (lat_done) begin
               ack_q    <= 1'b1;
               status_q <= ST_IDLE;
               state_q  <= S_RX_ON;
            end
            default: state_q <= S_RX_ON;
         endcase
      end
   end

   assign busy_rx     = (state_q == S_BUSY);
   assign rx_done_irq = irq_q;
   assign status      = status_q;
   assign ack_start   = ack_q;
endmodule

// File: rtl/ack_timing_ctrl_chk.sv
module ack_timing_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sfd_pulse,
   input logic       eof_pulse,
   input logic       eof_ack_req,
   input logic       busy_rx,
   input logic       rx_done_irq,
   input logic [1:0] status,
   input logic       ack_start
);
   // R2
   busy_from_sfd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_rx) |-> $past(sfd_pulse));

   // R3
   irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done_irq |=> !rx_done_irq);

   // R3
   irq_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done_irq |-> (!busy_rx && $past(busy_rx) && $past(eof_pulse)));

   // R4
   no_req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done_irq && !$past(eof_ack_req)) |=> (!ack_start && status == 2'b00));

   // R5
   ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_start |=> !ack_start);

   // R10
   ack_idle_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_start |-> (status == 2'b00 && !busy_rx));

   // R7
   wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status == 2'b01) |-> (!busy_rx && !ack_start && !rx_done_irq));

   // R1
   status_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status[1] == 1'b0);
endmodule

bind ack_timing_ctrl ack_timing_ctrl_chk i_chk (
   .clk(clk), .rst_n(rst_n), .sfd_pulse(sfd_pulse), .eof_pulse(eof_pulse),
   .eof_ack_req(eof_ack_req), .busy_rx(busy_rx), .rx_done_irq(rx_done_irq),
   .status(status), .ack_start(ack_start)
);

// File: tb/test_ack_timing_ctrl.sv
module test_ack_timing_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int READY = 6, SHORTN = 2, LONGN = 12, LAT = 16, SYNC = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sfd_pulse = 0, eof_pulse = 0, eof_ack_req = 0, sym_tick = 0;
   logic cfg_slotted = 0, cfg_short_turn = 0, trig_pin = 0;
   logic busy_rx, rx_done_irq, ack_start;
   logic [1:0] status;
   int checks = 0, fails = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ack_timing_ctrl #(.READY_SYM(READY), .SHORT_SYM(SHORTN), .LONG_SYM(LONGN),
                     .TRIG_LAT_CYC(LAT), .TRIG_SYNC_STAGES(SYNC)) i_ack_timing_ctrl (
      .clk(clk), .rst_n(rst_n), .sfd_pulse(sfd_pulse), .eof_pulse(eof_pulse),
      .eof_ack_req(eof_ack_req), .sym_tick(sym_tick), .cfg_slotted(cfg_slotted),
      .cfg_short_turn(cfg_short_turn), .trig_pin(trig_pin), .busy_rx(busy_rx),
      .rx_done_irq(rx_done_irq), .status(status), .ack_start(ack_start));

   function automatic int exp_symbols(input bit slot, input bit shrt);
      return slot ? READY : (shrt ? SHORTN : LONGN);
   endfunction

   function automatic int exp_trig_cycles();
      return SYNC + LAT + 1;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic idle_cycles(input int n);
      for (int i = 0; i < n; i++) begin
         cyc();
         chk(ack_start == 0, "R9 quiet ack", ack_start, 0);
      end
   endtask

   task automatic tick();
      sym_tick = 1; cyc(); sym_tick = 0;
   endtask

   task automatic trig_pulse();
      trig_pin = 1; idle_cycles(3); trig_pin = 0; idle_cycles(4);
   endtask

   task automatic frame(input bit req, input bit slot, input bit shrt,
                        input bit early, input bit flip);
      int n, target;
      if (early) trig_pulse();                        // R9: no ack pending
      chk(status == 2'b00, "R9 idle status", status, 0);
      sfd_pulse = 1; cyc(); sfd_pulse = 0;
      chk(busy_rx == 1, "R2 busy", busy_rx, 1);
      for (int g = 0; g < int'($urandom_range(0, 3)); g++) begin
         cyc(); chk(busy_rx == 1, "R2 busy held", busy_rx, 1);
      end
      cfg_slotted = slot; cfg_short_turn = shrt; eof_ack_req = req; eof_pulse = 1;
      cyc();
      eof_pulse = 0; eof_ack_req = 0;
      chk(rx_done_irq == 1 && busy_rx == 0, "R3 irq", {rx_done_irq, busy_rx}, 2);
      if (flip) begin cfg_slotted = ~slot; cfg_short_turn = ~shrt; end   // R11
      cyc();
      chk(rx_done_irq == 0, "R3 irq single", rx_done_irq, 0);
      if (!req) begin
         for (int i = 0; i < LONGN + 2; i++) begin
            tick();
            chk(ack_start == 0 && status == 2'b00, "R4 no ack", {ack_start, status}, 0);
         end
         return;
      end
      target = exp_symbols(slot, shrt);
      for (int i = 1; i <= target; i++) begin
         if (slot && early && i == 2) trig_pulse();  // R9: before ready point
         tick();
         if (slot)
            chk(status == ((i == target) ? 2'b01 : 2'b00) && ack_start == 0,
                "R7 status", status, (i == target) ? 1 : 0);
         else
            chk(ack_start == (i == target), shrt ? "R6 short ack" : "R5 long ack",
                ack_start, (i == target) ? 1 : 0);
         if (i != target) idle_cycles($urandom_range(0, 2));
      end
      if (!slot) begin
         cyc();
         chk(ack_start == 0 && status == 2'b00, "R10 after ack", {ack_start, status}, 0);
         return;
      end
      for (int i = 0; i < 3; i++) begin
         tick();
         chk(status == 2'b01 && ack_start == 0, "R7 hold wait", {ack_start, status}, 1);
      end
      trig_pin = 1; n = 0;
      while (n < 100) begin
         cyc(); n++;
         if (ack_start) break;
      end
      trig_pin = 0;
      chk(n == exp_trig_cycles(), "R8 trigger latency", n, exp_trig_cycles());
      chk(status == 2'b00, "R10 status idle at ack", status, 0);
      cyc();
      chk(ack_start == 0, "R10 ack single", ack_start, 0);
      idle_cycles(3);
   endtask

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      chk(busy_rx == 0 && rx_done_irq == 0 && ack_start == 0 && status == 2'b00,
          "R1 reset", {busy_rx, rx_done_irq, ack_start, status}, 0);
      rst_n = 1;
      cyc();
      chk(busy_rx == 0 && status == 2'b00, "R1 after release", {busy_rx, status}, 0);
      // directed corners
      frame(1, 0, 0, 0, 0);   // R5
      frame(1, 0, 1, 0, 0);   // R6
      frame(1, 1, 0, 1, 0);   // R7 R8 R9
      frame(0, 1, 1, 0, 0);   // R4
      frame(1, 0, 1, 0, 1);   // R11 short captured
      frame(1, 1, 0, 0, 1);   // R11 slotted captured
      // eof outside busy and sfd while pending ignored
      eof_pulse = 1; cyc(); eof_pulse = 0;
      chk(rx_done_irq == 0, "R3 eof ignored when idle", rx_done_irq, 0);
      for (int k = 0; k < 40; k++) begin
         frame($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 1),
               $urandom_range(0, 1), $urandom_range(0, 1));
         idle_cycles($urandom_range(0, 4));
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule